// File: doc/BRIEF.md
# Dual DMA Channel Register File

This block holds the programming state of eight DMA channels, split into two controllers of four channels each. Software reaches it over a byte-wide I/O port bus. Each channel keeps a 16-bit address register and a 16-bit count register. Each of these has a base copy and a current copy, and a bus write loads both copies. Each channel also has a 6-bit mode field, a mask bit and an 8-bit page byte.

The 16-bit registers are reached one byte at a time. A byte pointer selects the byte, and each controller has one pointer that all of its channels share. A write to the controller's clear port resets that pointer. The second controller decodes only even port addresses, and its register offsets are twice those of the first. The page bytes sit at eight fixed, irregular port addresses.

A transfer engine reads the current address, count, page, mode and mask of each channel from the outputs. For every unit it moves on channel *n*, it pulses `xfer_step[n]`. On each pulse the current count goes down by one and the current address goes up by one. When the count passes zero, a channel with auto-initialise set reloads both current registers from their base copies.

Top module: `dual_dma_regfile`

## Requirements
- R1: While `rst` is high, and after it falls, all eight mask bits are 1. Every address, count, page and mode register is 0, both byte pointers select the low byte, and `io_rdata` is 0.
- R2: The first controller sits at ports 0x00–0x0C. Channel c (0–3) has its address register at 2c and its count register at 2c+1. A byte write there loads the same byte of both the base copy and the current copy.
- R3: The second controller's channel c (4–7) has its address register at 0xC0+4(c−4) and its count register at 0xC0+4(c−4)+2. Writes to odd addresses from 0xC1 to 0xD9 change no register and no byte pointer.
- R4: Each controller has one byte pointer. Every read or write of one of its address or count ports moves the pointer to the other byte, whichever channel the port belongs to. The two controllers' pointers are independent.
- R5: A write of any data to the clear port (0x0C or 0xD8) sets that controller's pointer to the low byte.
- R6: The page bytes of channels 0–7 are at ports 0x87, 0x83, 0x81, 0x82, 0x8F, 0x8B, 0x89 and 0x8A. They can be written and read back, and a page access leaves both byte pointers unchanged.
- R7: A write to the mask port (0x0A or 0xD4) uses data bits 1:0 to pick the channel within the controller. It sets that channel's mask to data bit 2.
- R8: A write to the mode port (0x0B or 0xD6) uses data bits 1:0 to pick the channel. It stores data bits 7:2 in `ch_mode_o`. Data bit 4 (mode bit 2) is auto-initialise, bits 3:2 are the transfer type and bits 7:6 are the operating mode.
- R9: A `xfer_step` pulse on an unmasked channel with a nonzero current count lowers the count by 1 and raises the address by 1 at the next clock edge. On a masked channel a pulse changes nothing.
- R10: A pulse at current count 0 has two outcomes. Without auto-initialise the count becomes 0xFFFF and the address goes up by 1. With auto-initialise both current registers reload from their base copies.
- R11: `io_rdata` is registered on the edge that samples `io_rd`. An address or count read returns the byte of the current copy that the pointer selects. A read of a mask, mode, clear or unmapped port returns 0.
- R12: A bus write to a channel's address or count register cancels a `xfer_step` pulse on that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe (ignored when `io_wr` is high) |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| xfer_step | input | 8 | One pulse per unit moved, one bit per channel |
| ch_addr_o | output | 128 | Current address, 16 bits per channel, channel 0 in the low bits |
| ch_count_o | output | 128 | Current count, 16 bits per channel |
| ch_page_o | output | 64 | Page byte per channel |
| ch_mode_o | output | 48 | Mode field per channel (data bits 7:2) |
| ch_mask_o | output | 8 | Mask bit per channel |

## Verification
The hardest state to reach from the ports is a byte pointer that has been left out of step on purpose. That is the state in which a write lands in the high byte of a register other than the one last touched, or in which odd second-controller writes or page accesses could disturb the pointer. The stimulus produces it by leaving pointers half-way on purpose: one byte goes to one channel, the next byte goes to a different channel of the same controller, and sweeps of every odd address in the second window run between partial writes. The terminal-count reload is reached by programming small counts, stepping each channel through zero with and without auto-initialise, and pulsing a step in the same cycle as a count write.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int DW      = 8;
  localparam int REG_W   = 2 * DW;
  localparam int NCTL    = 2;
  localparam int CPC     = 4;
  localparam int NCH     = NCTL * CPC;
  localparam int CH_W    = $clog2(NCH);
  localparam int CPC_W   = $clog2(CPC);
  localparam int CTL_W   = (NCTL > 1) ? $clog2(NCTL) : 1;
  localparam int MODE_W  = DW - CPC_W;
  localparam int AUTO_BIT = 2;
  localparam int OFF_MASK = 2 * CPC + 2;
  localparam int OFF_MODE = OFF_MASK + 1;
  localparam int OFF_CLR  = OFF_MODE + 1;
  localparam int SPAN     = OFF_CLR + 1;

  typedef enum logic [2:0] {
    RK_NONE, RK_ADDR, RK_CNT, RK_MASK, RK_MODE, RK_CLR, RK_PAGE
  } reg_kind_e;

  function automatic logic [7:0] page_port(input int ch);
    case (ch)
      0: page_port = 8'h87;
      1: page_port = 8'h83;
      2: page_port = 8'h81;
      3: page_port = 8'h82;
      4: page_port = 8'h8F;
      5: page_port = 8'h8B;
      6: page_port = 8'h89;
      default: page_port = 8'h8A;
    endcase
  endfunction
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_rf_pkg::*;
#(
  parameter int            AW      = 8,
  parameter logic [AW-1:0] C1_BASE = 8'h00,
  parameter logic [AW-1:0] C2_BASE = 8'hC0
) (
  input  logic [AW-1:0]    io_addr,
  output reg_kind_e        kind,
  output logic [CTL_W-1:0] ctl,
  output logic [CH_W-1:0]  chan,
  output logic             odd_hit
);
  logic [AW-1:0] off1, off2, off;
  logic          in_rng;

  always_comb begin
    kind    = RK_NONE;
    ctl     = '0;
    chan    = '0;
    off     = '0;
    in_rng  = 1'b0;
    off1    = io_addr - C1_BASE;
    off2    = io_addr - C2_BASE;
    odd_hit = (off2 < AW'(2 * SPAN)) && off2[0];
    if (off1 < AW'(SPAN)) begin
      off    = off1;
      in_rng = 1'b1;
    end else if ((off2 < AW'(2 * SPAN)) && !off2[0]) begin
      off    = off2 >> 1;
      in_rng = 1'b1;
      ctl    = CTL_W'(1);
    end
    if (in_rng) begin
      if (off < AW'(2 * CPC)) begin
        kind = off[0] ? RK_CNT : RK_ADDR;
        chan = CH_W'(int'(ctl) * CPC + int'(off >> 1));
      end else if (off == AW'(OFF_MASK)) begin
        kind = RK_MASK;
      end else if (off == AW'(OFF_MODE)) begin
        kind = RK_MODE;
      end else if (off == AW'(OFF_CLR)) begin
        kind = RK_CLR;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (io_addr == AW'(page_port(i))) begin
        kind = RK_PAGE;
        chan = CH_W'(i);
        ctl  = CTL_W'(i / CPC);
      end
    end
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic acc,
  output logic ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= 1'b0;
    else if (clr) ptr_q <= 1'b0;
    else if (acc) ptr_q <= ~ptr_q;
  end

  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst) clr |=> !ptr_q);

  // R4
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !clr) |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic              wr_mask,
  input  logic              wr_hi,
  input  logic [DW-1:0]     wdata,
  input  logic              step,
  output logic [REG_W-1:0]  cur_addr_q,
  output logic [REG_W-1:0]  cur_cnt_q,
  output logic [DW-1:0]     page_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              mask_q
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q;
  logic             do_step;

  assign do_step = step && !mask_q && !wr_addr && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
    end else begin
      if (do_step) begin
        if (cur_cnt_q == '0) begin
          if (mode_q[AUTO_BIT]) begin
            cur_cnt_q  <= base_cnt_q;
            cur_addr_q <= base_addr_q;
          end else begin
            cur_cnt_q  <= '1;
            cur_addr_q <= cur_addr_q + 1'b1;
          end
        end else begin
          cur_cnt_q  <= cur_cnt_q - 1'b1;
          cur_addr_q <= cur_addr_q + 1'b1;
        end
      end
      if (wr_addr) begin
        if (wr_hi) begin
          base_addr_q[REG_W-1:DW] <= wdata;
          cur_addr_q[REG_W-1:DW]  <= wdata;
        end else begin
          base_addr_q[DW-1:0] <= wdata;
          cur_addr_q[DW-1:0]  <= wdata;
        end
      end
      if (wr_cnt) begin
        if (wr_hi) begin
          base_cnt_q[REG_W-1:DW] <= wdata;
          cur_cnt_q[REG_W-1:DW]  <= wdata;
        end else begin
          base_cnt_q[DW-1:0] <= wdata;
          cur_cnt_q[DW-1:0]  <= wdata;
        end
      end
      if (wr_page) page_q <= wdata;
      if (wr_mode) mode_q <= wdata[DW-1:CPC_W];
      if (wr_mask) mask_q <= wdata[CPC_W];
    end
  end

  // R9
  masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !wr_addr && !wr_cnt) |=> ($stable(cur_cnt_q) && $stable(cur_addr_q)));

  // R9
  step_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !mask_q && !wr_addr && !wr_cnt && cur_cnt_q != '0)
      |=> (cur_cnt_q == $past(cur_cnt_q) - 1'b1));

  // R10
  auto_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !mask_q && !wr_addr && !wr_cnt && cur_cnt_q == '0 && mode_q[AUTO_BIT])
      |=> (cur_cnt_q == base_cnt_q && cur_addr_q == base_addr_q));

  // R7
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_q == $past(wdata[CPC_W])));
endmodule

// File: rtl/dual_dma_regfile.sv
module dual_dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int            AW      = 8,
  parameter logic [AW-1:0] C1_BASE = 8'h00,
  parameter logic [AW-1:0] C2_BASE = 8'hC0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic [AW-1:0]           io_addr,
  input  logic [DW-1:0]           io_wdata,
  output logic [DW-1:0]           io_rdata,
  input  logic [NCH-1:0]          xfer_step,
  output logic [NCH*REG_W-1:0]    ch_addr_o,
  output logic [NCH*REG_W-1:0]    ch_count_o,
  output logic [NCH*DW-1:0]       ch_page_o,
  output logic [NCH*MODE_W-1:0]   ch_mode_o,
  output logic [NCH-1:0]          ch_mask_o
);
  reg_kind_e        dec_kind;
  logic [CTL_W-1:0] dec_ctl;
  logic [CH_W-1:0]  dec_chan;
  logic             dec_odd;
  logic             wr_en, rd_en, reg_acc;
  logic [NCTL-1:0]  ptr_q;

  logic [REG_W-1:0] cur_addr [NCH];
  logic [REG_W-1:0] cur_cnt  [NCH];
  logic [DW-1:0]    page     [NCH];

  assign wr_en   = io_wr;
  assign rd_en   = io_rd && !io_wr;
  assign reg_acc = (wr_en || rd_en) && (dec_kind == RK_ADDR || dec_kind == RK_CNT);

  dma_port_decode #(.AW(AW), .C1_BASE(C1_BASE), .C2_BASE(C2_BASE)) u_dec (
    .io_addr (io_addr),
    .kind    (dec_kind),
    .ctl     (dec_ctl),
    .chan    (dec_chan),
    .odd_hit (dec_odd)
  );

  for (genvar k = 0; k < NCTL; k++) begin : g_ptr
    logic sel;
    assign sel = (int'(dec_ctl) == k);
    dma_byte_ptr u_ptr (
      .clk   (clk),
      .rst   (rst),
      .clr   (wr_en && dec_kind == RK_CLR && sel),
      .acc   (reg_acc && sel),
      .ptr_q (ptr_q[k])
    );
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int CTL = g / CPC;
    logic hit_reg, hit_cmd;
    assign hit_reg = (dec_chan == CH_W'(g));
    assign hit_cmd = (int'(dec_ctl) == CTL) && (io_wdata[CPC_W-1:0] == CPC_W'(g % CPC));

    dma_chan_regs u_ch (
      .clk        (clk),
      .rst        (rst),
      .wr_addr    (wr_en && dec_kind == RK_ADDR && hit_reg),
      .wr_cnt     (wr_en && dec_kind == RK_CNT && hit_reg),
      .wr_page    (wr_en && dec_kind == RK_PAGE && hit_reg),
      .wr_mode    (wr_en && dec_kind == RK_MODE && hit_cmd),
      .wr_mask    (wr_en && dec_kind == RK_MASK && hit_cmd),
      .wr_hi      (ptr_q[CTL]),
      .wdata      (io_wdata),
      .step       (xfer_step[g]),
      .cur_addr_q (cur_addr[g]),
      .cur_cnt_q  (cur_cnt[g]),
      .page_q     (page[g]),
      .mode_q     (ch_mode_o[g*MODE_W +: MODE_W]),
      .mask_q     (ch_mask_o[g])
    );

    assign ch_addr_o[g*REG_W +: REG_W]  = cur_addr[g];
    assign ch_count_o[g*REG_W +: REG_W] = cur_cnt[g];
    assign ch_page_o[g*DW +: DW]        = page[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (rd_en) begin
      case (dec_kind)
        RK_ADDR: io_rdata <= ptr_q[dec_ctl] ? cur_addr[dec_chan][REG_W-1:DW]
                                            : cur_addr[dec_chan][DW-1:0];
        RK_CNT:  io_rdata <= ptr_q[dec_ctl] ? cur_cnt[dec_chan][REG_W-1:DW]
                                            : cur_cnt[dec_chan][DW-1:0];
        RK_PAGE: io_rdata <= page[dec_chan];
        default: io_rdata <= '0;
      endcase
    end
  end

  // R3
  odd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && dec_odd) |=> ($stable(ch_mask_o) && $stable(ch_mode_o) && $stable(ch_page_o)
                            && $stable(ptr_q)));

  // R11
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (dec_kind == RK_MASK || dec_kind == RK_MODE || dec_kind == RK_CLR
               || dec_kind == RK_NONE)) |=> (io_rdata == '0));

  // R6
  page_ptr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && dec_kind == RK_PAGE) |=> $stable(ptr_q));
endmodule

// File: tb/test_dual_dma_regfile.sv
module test_dual_dma_regfile;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]   io_addr = '0, io_wdata = '0;
  logic [7:0]   xfer_step = '0;
  logic [7:0]   io_rdata;
  logic [127:0] ch_addr_o, ch_count_o;
  logic [63:0]  ch_page_o;
  logic [47:0]  ch_mode_o;
  logic [7:0]   ch_mask_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dma_regfile i_dual_dma_regfile (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_step(xfer_step),
    .ch_addr_o(ch_addr_o), .ch_count_o(ch_count_o), .ch_page_o(ch_page_o),
    .ch_mode_o(ch_mode_o), .ch_mask_o(ch_mask_o)
  );

  int checks = 0, errors = 0;

  logic [15:0] m_ba [8], m_ca [8], m_bc [8], m_cc [8];
  logic [7:0]  m_pg [8];
  logic [5:0]  m_md [8];
  logic [7:0]  m_mk, m_rd;
  logic [1:0]  m_ptr;

  function automatic logic [7:0] p_addr(input int ch);
    return (ch < 4) ? 8'(2 * ch) : 8'(8'hC0 + 4 * (ch - 4));
  endfunction
  function automatic logic [7:0] p_cnt(input int ch);
    return (ch < 4) ? 8'(2 * ch + 1) : 8'(8'hC0 + 4 * (ch - 4) + 2);
  endfunction
  function automatic logic [7:0] p_mask(input int t); return t ? 8'hD4 : 8'h0A; endfunction
  function automatic logic [7:0] p_mode(input int t); return t ? 8'hD6 : 8'h0B; endfunction
  function automatic logic [7:0] p_clr (input int t); return t ? 8'hD8 : 8'h0C; endfunction
  function automatic logic [7:0] p_page(input int ch);
    case (ch)
      0: return 8'h87; 1: return 8'h83; 2: return 8'h81; 3: return 8'h82;
      4: return 8'h8F; 5: return 8'h8B; 6: return 8'h89; default: return 8'h8A;
    endcase
  endfunction

  // kinds: 0 none, 1 addr, 2 count, 3 mask, 4 mode, 5 clear, 6 page
  task automatic bdec(input logic [7:0] a, output int k, output int c);
    int o, b;
    k = 0; c = 0; o = -1; b = 0;
    if (a <= 8'd12) o = int'(a);
    else if (a >= 8'hC0 && a <= 8'hD8 && !a[0]) begin o = (int'(a) - 'hC0) / 2; b = 4; end
    if (o >= 0) begin
      if (o < 8) begin k = (o % 2 == 1) ? 2 : 1; c = b + o / 2; end
      else if (o == 10) begin k = 3; c = b; end
      else if (o == 11) begin k = 4; c = b; end
      else if (o == 12) begin k = 5; c = b; end
    end
    for (int i = 0; i < 8; i++) if (a == p_page(i)) begin k = 6; c = i; end
  endtask

  task automatic model(input logic w, input logic r, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] st);
    int k, c, t;
    bdec(a, k, c);
    t = c / 4;
    if (r && !w) begin
      case (k)
        1: m_rd = m_ptr[t] ? m_ca[c][15:8] : m_ca[c][7:0];
        2: m_rd = m_ptr[t] ? m_cc[c][15:8] : m_cc[c][7:0];
        6: m_rd = m_pg[c];
        default: m_rd = 8'h00;
      endcase
    end
    for (int i = 0; i < 8; i++) begin
      if (st[i] && !m_mk[i] && !(w && (k == 1 || k == 2) && c == i)) begin
        if (m_cc[i] == 16'h0) begin
          if (m_md[i][2]) begin m_cc[i] = m_bc[i]; m_ca[i] = m_ba[i]; end
          else begin m_cc[i] = 16'hFFFF; m_ca[i] = m_ca[i] + 16'd1; end
        end else begin
          m_cc[i] = m_cc[i] - 16'd1; m_ca[i] = m_ca[i] + 16'd1;
        end
      end
    end
    if (w) begin
      case (k)
        1: if (m_ptr[t]) begin m_ba[c][15:8] = d; m_ca[c][15:8] = d; end
           else begin m_ba[c][7:0] = d; m_ca[c][7:0] = d; end
        2: if (m_ptr[t]) begin m_bc[c][15:8] = d; m_cc[c][15:8] = d; end
           else begin m_bc[c][7:0] = d; m_cc[c][7:0] = d; end
        3: m_mk[c + int'(d[1:0])] = d[2];
        4: m_md[c + int'(d[1:0])] = d[7:2];
        5: m_ptr[t] = 1'b0;
        6: m_pg[c] = d;
        default: ;
      endcase
    end
    if ((w || r) && (k == 1 || k == 2)) m_ptr[t] = ~m_ptr[t];
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [7:0] d, input logic [7:0] st);
    model(w, r, a, d, st);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d; xfer_step = st;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; xfer_step = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(1'b1, 1'b0, a, d, 8'h00); endtask
  task automatic rd(input logic [7:0] a); cyc(1'b0, 1'b1, a, 8'h00, 8'h00); endtask
  task automatic stp(input logic [7:0] st); cyc(1'b0, 1'b0, 8'hFF, 8'h00, st); endtask

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic [127:0] ea, ec; logic [63:0] ep; logic [47:0] em;
    for (int i = 0; i < 8; i++) begin
      ea[i*16 +: 16] = m_ca[i]; ec[i*16 +: 16] = m_cc[i];
      ep[i*8 +: 8] = m_pg[i];   em[i*6 +: 6] = m_md[i];
    end
    chk(req, "addr", ch_addr_o, ea);
    chk(req, "count", ch_count_o, ec);
    chk(req, "page", {64'h0, ch_page_o}, {64'h0, ep});
    chk(req, "mode", {80'h0, ch_mode_o}, {80'h0, em});
    chk(req, "mask", {120'h0, ch_mask_o}, {120'h0, m_mk});
  endtask

  task automatic chk_rd(input string req);
    chk(req, "rdata", {120'h0, io_rdata}, {120'h0, m_rd});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_pg[i] = 0; m_md[i] = 0;
    end
    m_mk = 8'hFF; m_rd = 8'h00; m_ptr = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1"); chk_rd("R1");

    // R2 R3 program every channel through its own ports
    for (int ch = 0; ch < 8; ch++) begin
      logic [15:0] av, cv;
      av = 16'(ch * 16'h1111 + 16'h0203);
      cv = 16'(ch * 16'h0321 + 16'h0010);
      wr(p_clr(ch / 4), 8'h5A);
      wr(p_addr(ch), av[7:0]); wr(p_addr(ch), av[15:8]);
      wr(p_cnt(ch), cv[7:0]);  wr(p_cnt(ch), cv[15:8]);
      wr(p_page(ch), 8'(8'h30 + ch * 7));
      chk_all(ch < 4 ? "R2" : "R3");
    end

    // R11 R6 read back through the ports
    for (int ch = 0; ch < 8; ch++) begin
      wr(p_clr(ch / 4), 8'h00);
      rd(p_addr(ch)); chk_rd("R11");
      rd(p_addr(ch)); chk_rd("R11");
      rd(p_cnt(ch));  chk_rd("R11");
      rd(p_cnt(ch));  chk_rd("R11");
      rd(p_page(ch)); chk_rd("R6");
    end

    // R4 pointer shared across one controller's channels, independent between controllers
    wr(p_clr(0), 8'h00); wr(p_clr(1), 8'h00);
    wr(p_addr(0), 8'hA1);
    wr(p_addr(5), 8'hB2);
    wr(p_cnt(2), 8'hC3);
    wr(p_cnt(6), 8'hD4);
    chk_all("R4");
    rd(p_addr(3)); chk_rd("R4");
    wr(p_addr(1), 8'hE5);
    chk_all("R4");

    // R5 clear mid-way sends the next access to the low byte
    wr(p_addr(4), 8'h11);
    wr(p_clr(1), 8'hFF);
    wr(p_addr(4), 8'h22);
    chk_all("R5");

    // R3 odd second-controller addresses ignored, pointer untouched
    wr(p_addr(7), 8'h66);
    for (int a = 'hC1; a <= 'hD9; a += 2) wr(8'(a), 8'hFF);
    chk_all("R3");
    wr(p_addr(7), 8'h77);
    chk_all("R3");

    // R6 page access leaves pointer alone
    wr(p_clr(0), 8'h00);
    wr(p_page(2), 8'h9C);
    rd(p_page(1));
    wr(p_addr(2), 8'h44);
    chk_all("R6"); chk_rd("R6");

    // R7 mask per channel
    for (int ch = 0; ch < 8; ch++) begin
      wr(p_mask(ch / 4), 8'(ch % 4)); chk_all("R7");
    end
    for (int ch = 0; ch < 8; ch += 2) begin
      wr(p_mask(ch / 4), 8'(4 | (ch % 4))); chk_all("R7");
    end

    // R8 mode per channel
    for (int ch = 0; ch < 8; ch++) begin
      wr(p_mode(ch / 4), 8'((((ch * 37 + 5) << 2) | (ch % 4)) & 8'hFF)); chk_all("R8");
    end

    // R11 write-only and unmapped ports read as zero
    rd(8'h0A); chk_rd("R11");
    rd(8'hD6); chk_rd("R11");
    rd(8'h50); chk_rd("R11");

    // R9 R10 non-auto channel 1 stepped through zero
    wr(p_mode(0), 8'h45);
    wr(p_clr(0), 8'h00);
    wr(p_addr(1), 8'h00); wr(p_addr(1), 8'h01);
    wr(p_cnt(1), 8'h02);  wr(p_cnt(1), 8'h00);
    wr(p_mask(0), 8'h01);
    stp(8'h02); chk_all("R9");
    stp(8'h02); chk_all("R9");
    stp(8'h02); chk_all("R10");
    stp(8'h02); chk_all("R10");

    // R9 masked channel ignores steps
    wr(p_mask(0), 8'h07);
    stp(8'h08); chk_all("R9");

    // R10 auto-initialise on channel 5
    wr(p_mode(1), 8'h51);
    wr(p_clr(1), 8'h00);
    wr(p_addr(5), 8'h40); wr(p_addr(5), 8'h20);
    wr(p_cnt(5), 8'h01);  wr(p_cnt(5), 8'h00);
    wr(p_mask(1), 8'h01);
    for (int n = 0; n < 3; n++) begin stp(8'h20); chk_all("R10"); end

    // R9 all channels unmasked and stepped together
    for (int ch = 0; ch < 8; ch++) wr(p_mask(ch / 4), 8'(ch % 4));
    for (int n = 0; n < 3; n++) begin stp(8'hFF); chk_all("R9"); end

    // R12 count write beats a same-cycle step
    wr(p_clr(0), 8'h00);
    cyc(1'b1, 1'b0, p_cnt(1), 8'h77, 8'h02);
    chk_all("R12");
    cyc(1'b1, 1'b0, p_addr(1), 8'h13, 8'h03);
    chk_all("R12");

    // R11 count read returns current value
    wr(p_clr(0), 8'h00);
    rd(p_cnt(1)); chk_rd("R11");
    rd(p_cnt(1)); chk_rd("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule